// File: doc/BRIEF.md
# Master Interrupt Aggregator with Message Trigger

This block is the top-level interrupt collector of a device. Each leaf interrupt group hands it a 32-bit summary of its enabled pending events, meaning pending bits already qualified by that group's enable. The block folds these summaries into one 32-bit master word using a fixed, sparse bit assignment. The two main engine groups are split into a lower half and an upper half. The other groups collapse to a single bit each.

Bit 31 of the master word is the only bit software can change. It acts as a global gate. While the gate is open, the summary bits track their sources cycle by cycle. While it is closed, they keep their last value.

A message-signalled interrupt pulse is raised when three things hold together:
- the gate is open;
- some summary bit is set;
- the message capability control field selects exactly the single-message format.

The pulse is one cycle long and fires only on the rising edge of that combined condition. A condition that stays true therefore produces no further pulses.

Top module: `irq_master_aggr`

## Requirements
- R1: A write (`wr_en`=1) stores `wr_data[31]` into master bit 31, visible in `master_o` one cycle later. Bits 30:0 of `wr_data` are ignored.
- R2: Engine summary mapping. Master bit 0 = OR of `eng0_pend[15:0]`, bit 1 = OR of `eng0_pend[31:16]`, bit 2 = OR of `eng1_pend[15:0]`, bit 3 = OR of `eng1_pend[31:16]`, bit 4 = OR of `eng2_pend[15:0]`, bit 6 = OR of `eng3_pend[15:0]`. The upper halves of `eng2_pend` and `eng3_pend` drive nothing.
- R3: Other group mapping, each bit the OR of the whole 32-bit input. Bits 16, 17 and 18 come from pipes A, B and C. Bit 20 comes from the port group, bit 22 from the misc group, bit 23 from the south-bridge group and bit 30 from the power-unit group.
- R4: Master bits 5, 7 to 15, 19, 21 and 24 to 29 always read 0.
- R5: While bit 31 is 1, each summary bit shows its source as sampled at the previous clock edge. It sets when the source is nonzero and clears when the source is zero.
- R6: While bit 31 is 0, summary bits 30:0 hold their value whatever the sources do.
- R7: The message condition requires bit 31 = 1 and at least one of master bits 30:0 = 1.
- R8: The message condition also requires `msg_ctrl[0]` = 1 and `msg_ctrl[15:1]` = 0. Any other control value suppresses the message.
- R9: `msg_pulse` is high for exactly one cycle. It goes high in the cycle after the combined condition (R7 and R8) turns from false to true, and does not fire again while the condition stays true.
- R10: After reset, `master_o` is 0 and `msg_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eng0_pend | input | 32 | Engine group 0 enabled pending summary |
| eng1_pend | input | 32 | Engine group 1 enabled pending summary |
| eng2_pend | input | 32 | Engine group 2 enabled pending summary |
| eng3_pend | input | 32 | Engine group 3 enabled pending summary |
| pipe_a_pend | input | 32 | Display pipe A enabled pending summary |
| pipe_b_pend | input | 32 | Display pipe B enabled pending summary |
| pipe_c_pend | input | 32 | Display pipe C enabled pending summary |
| port_pend | input | 32 | Display port group enabled pending summary |
| misc_pend | input | 32 | Display misc group enabled pending summary |
| south_pend | input | 32 | South-bridge group enabled pending summary |
| power_pend | input | 32 | Power-unit group enabled pending summary |
| wr_en | input | 1 | Master register write strobe |
| wr_data | input | 32 | Master register write data (only bit 31 used) |
| msg_ctrl | input | 16 | Message capability control field |
| master_o | output | 32 | Master register value |
| msg_pulse | output | 1 | One-cycle message interrupt request |

## Verification
A wrong mapping entry shows up in `master_o` one cycle after a single-bit pattern is applied: the wrong master bit is lit, or an unmapped one is. A gate that fails to freeze the summary shows as bits changing while bit 31 is clear, in the very next cycle. A faulty edge detector or a faulty capability check shows at `msg_pulse` within two cycles of the condition changing. It appears as a missing pulse, a repeated pulse while the level is held, or a pulse under an invalid control value.

// File: rtl/irq_master_pkg.sv
// Package: shared constants for the master interrupt aggregator.
// Holds the register width, the gate bit position, the source count and
// the fixed source-to-summary-bit assignment with the span each source uses.
package irq_master_pkg;

    localparam int unsigned REG_W      = 32;
    localparam int unsigned GATE_BIT   = REG_W - 1;
    localparam int unsigned CTRL_W     = 16;
    localparam int unsigned NUM_SRC    = 13;

    // Which part of a 32-bit source feeds its summary bit.
    localparam logic [1:0] SPAN_LOW  = 2'd0;
    localparam logic [1:0] SPAN_HIGH = 2'd1;
    localparam logic [1:0] SPAN_FULL = 2'd2;

    // Source order: eng0 lo, eng0 hi, eng1 lo, eng1 hi, eng2 lo, eng3 lo,
    // pipe A, pipe B, pipe C, port, misc, south, power.
    localparam int unsigned SRC_BIT [NUM_SRC] =
        '{0, 1, 2, 3, 4, 6, 16, 17, 18, 20, 22, 23, 30};

    localparam logic [1:0] SRC_SPAN [NUM_SRC] =
        '{SPAN_LOW, SPAN_HIGH, SPAN_LOW, SPAN_HIGH, SPAN_LOW, SPAN_LOW,
          SPAN_FULL, SPAN_FULL, SPAN_FULL, SPAN_FULL, SPAN_FULL,
          SPAN_FULL, SPAN_FULL};

    // Returns the set of master bits that some source drives.
    function automatic logic [REG_W-1:0] mapped_bits();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[SRC_BIT[i]] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_sum_reduce.sv
// Module: irq_sum_reduce
// Reduces one source summary word to a single hit bit over the chosen span
// (lower half, upper half or whole word).
// Assumes W is even; the span is fixed at elaboration.
module irq_sum_reduce
    import irq_master_pkg::*;
#(
    parameter int unsigned W    = REG_W,
    parameter logic [1:0]  SPAN = SPAN_FULL
) (
    input  logic [W-1:0] pend,
    output logic         hit
);
    localparam int unsigned HALF = W / 2;

    logic [W-1:0] span_mask;

    // Pick the mask for the configured span.
    generate
        if (SPAN == SPAN_LOW) begin : g_low
            assign span_mask = {{HALF{1'b0}}, {HALF{1'b1}}};
        end else if (SPAN == SPAN_HIGH) begin : g_high
            assign span_mask = {{HALF{1'b1}}, {HALF{1'b0}}};
        end else begin : g_full
            assign span_mask = {W{1'b1}};
        end
    endgenerate

    // Any selected pending bit raises the hit.
    always_comb begin
        hit = |(pend & span_mask);
    end

endmodule

// File: rtl/irq_master_reg.sv
// Module: irq_master_reg
// Holds the master word: a software gate bit at the top and level-tracking
// summary bits below it. Summary bits follow their hits while the gate is
// set and freeze while it is clear. Unmapped bits stay at zero.
// Assumes the gate occupies the top bit of the word.
module irq_master_reg
    import irq_master_pkg::*;
#(
    parameter int unsigned W = REG_W,
    parameter int unsigned N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_gate,
    input  logic [N-1:0] hits,
    output logic [W-1:0] master
);
    localparam logic [W-1:0] LIVE_MASK = mapped_bits() | (W'(1) << GATE_BIT);

    logic         gate_q;
    logic [W-2:0] sum_q;
    logic [W-2:0] sum_nxt;

    // Scatter the hit bits into their master positions.
    always_comb begin
        sum_nxt = '0;
        for (int i = 0; i < N; i++) begin
            sum_nxt[SRC_BIT[i]] = sum_nxt[SRC_BIT[i]] | hits[i];
        end
    end

    // Gate bit: software-written, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (wr_en) begin
            gate_q <= wr_gate;
        end
    end

    // Summary bits: track while gated on, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (gate_q) begin
            sum_q <= sum_nxt;
        end
    end

    assign master = {gate_q, sum_q};

    a_r1_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> master[GATE_BIT] == $past(wr_gate));

    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (master & ~LIVE_MASK) == '0);

    a_r6_frozen_off: assert property (@(posedge clk) disable iff (!rst_n)
        !master[GATE_BIT] |=> $stable(master[W-2:0]));

endmodule

// File: rtl/irq_msg_trigger.sv
// Module: irq_msg_trigger
// Forms the message condition from the gate, the summary and the capability
// control, and emits a one-cycle pulse on its rising edge.
// Assumes control bit 0 is the enable and all higher bits must be zero.
module irq_msg_trigger
    import irq_master_pkg::*;
#(
    parameter int unsigned CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gate,
    input  logic          sum_any,
    input  logic [CW-1:0] ctrl,
    output logic          pulse
);
    logic cap_ok;
    logic cond;
    logic cond_q;
    logic pulse_q;

    // Single-message format with the enable set is the only accepted setting.
    always_comb begin
        cap_ok = ctrl[0] & ~(|ctrl[CW-1:1]);
        cond   = gate & sum_any & cap_ok;
    end

    // Edge detector: pulse once when the condition rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            cond_q  <= cond;
            pulse_q <= cond & ~cond_q;
        end
    end

    assign pulse = pulse_q;

    a_r7_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(gate && sum_any));

    a_r8_cap_required: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(ctrl[0] && ctrl[CW-1:1] == '0));

    a_r9_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/irq_master_aggr.sv
// Module: irq_master_aggr (top)
// Collects per-group enabled pending summaries into the master word and
// raises a message interrupt pulse. Inputs are already qualified by each
// group's own enable; leaf register logic lives elsewhere.
module irq_master_aggr
    import irq_master_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  eng0_pend,
    input  logic [REG_W-1:0]  eng1_pend,
    input  logic [REG_W-1:0]  eng2_pend,
    input  logic [REG_W-1:0]  eng3_pend,
    input  logic [REG_W-1:0]  pipe_a_pend,
    input  logic [REG_W-1:0]  pipe_b_pend,
    input  logic [REG_W-1:0]  pipe_c_pend,
    input  logic [REG_W-1:0]  port_pend,
    input  logic [REG_W-1:0]  misc_pend,
    input  logic [REG_W-1:0]  south_pend,
    input  logic [REG_W-1:0]  power_pend,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [CTRL_W-1:0] msg_ctrl,
    output logic [REG_W-1:0]  master_o,
    output logic              msg_pulse
);
    logic [REG_W-1:0] src [NUM_SRC];
    logic [NUM_SRC-1:0] hits;
    logic sum_any;

    // Source list in the package's mapping order.
    always_comb begin
        src[0]  = eng0_pend;
        src[1]  = eng0_pend;
        src[2]  = eng1_pend;
        src[3]  = eng1_pend;
        src[4]  = eng2_pend;
        src[5]  = eng3_pend;
        src[6]  = pipe_a_pend;
        src[7]  = pipe_b_pend;
        src[8]  = pipe_c_pend;
        src[9]  = port_pend;
        src[10] = misc_pend;
        src[11] = south_pend;
        src[12] = power_pend;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            irq_sum_reduce #(
                .W    (REG_W),
                .SPAN (SRC_SPAN[g])
            ) u_red (
                .pend (src[g]),
                .hit  (hits[g])
            );
        end
    endgenerate

    irq_master_reg #(
        .W (REG_W),
        .N (NUM_SRC)
    ) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_gate (wr_data[GATE_BIT]),
        .hits    (hits),
        .master  (master_o)
    );

    // Any summary bit below the gate counts as pending.
    always_comb begin
        sum_any = |master_o[GATE_BIT-1:0];
    end

    irq_msg_trigger #(
        .CW (CTRL_W)
    ) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (master_o[GATE_BIT]),
        .sum_any (sum_any),
        .ctrl    (msg_ctrl),
        .pulse   (msg_pulse)
    );

    a_r1_low_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !master_o[GATE_BIT] && wr_data[GATE_BIT-1:0] != '0)
            |=> master_o[GATE_BIT-1:0] == $past(master_o[GATE_BIT-1:0]));

endmodule

// File: tb/irq_master_aggr_test.sv
module irq_master_aggr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] e0 = '0, e1 = '0, e2 = '0, e3 = '0;
    logic [31:0] pa = '0, pb = '0, pc = '0, po = '0, mi = '0, so = '0, pw = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [15:0] ctrl = '0;
    logic [31:0] master_o;
    logic        msg_pulse;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    irq_master_aggr uut (
        .clk(clk), .rst_n(rst_n),
        .eng0_pend(e0), .eng1_pend(e1), .eng2_pend(e2), .eng3_pend(e3),
        .pipe_a_pend(pa), .pipe_b_pend(pb), .pipe_c_pend(pc),
        .port_pend(po), .misc_pend(mi), .south_pend(so), .power_pend(pw),
        .wr_en(wr_en), .wr_data(wr_data), .msg_ctrl(ctrl),
        .master_o(master_o), .msg_pulse(msg_pulse)
    );

    function automatic logic [31:0] exp_sum();
        logic [31:0] s;
        s = '0;
        s[0]  = |e0[15:0];
        s[1]  = |e0[31:16];
        s[2]  = |e1[15:0];
        s[3]  = |e1[31:16];
        s[4]  = |e2[15:0];
        s[6]  = |e3[15:0];
        s[16] = |pa;
        s[17] = |pb;
        s[18] = |pc;
        s[20] = |po;
        s[22] = |mi;
        s[23] = |so;
        s[30] = |pw;
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_all(input logic [31:0] v);
        @(negedge clk);
        e0 = v; e1 = v; e2 = v; e3 = v; pa = v; pb = v; pc = v;
        po = v; mi = v; so = v; pw = v;
        tick();
    endtask

    task automatic write_master(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        tick();
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (msg_pulse) cnt++;
        end
    endtask

    task automatic t_reset();
        check("R10 master", master_o, 32'h0);
        check("R10 pulse", {31'b0, msg_pulse}, 32'h0);
    endtask

    task automatic t_write();
        write_master(32'hFFFF_FFFF);
        check("R1 set gate only", master_o, 32'h8000_0000);
        write_master(32'h7FFF_FFFF);
        check("R1 clear gate, low ignored", master_o, 32'h0);
    endtask

    task automatic t_map();
        write_master(32'h8000_0000);
        for (int b = 0; b < 32; b++) begin
            set_all(32'h1 << b);
            check("R2 R3 R4 R5 mapping", master_o, 32'h8000_0000 | exp_sum());
        end
        set_all('0);
        check("R5 all cleared", master_o, 32'h8000_0000);
    endtask

    task automatic t_level();
        @(negedge clk); pa = 32'h0000_0100;
        tick();
        check("R5 pipe A set", master_o, 32'h8001_0000);
        @(negedge clk); pa = '0; pw = 32'h8000_0000;
        tick();
        check("R5 pipe A cleared, power set", master_o, 32'hC000_0000);
        @(negedge clk); pw = '0; e2 = 32'hFFFF_0000; e3 = 32'h0001_0000;
        tick();
        check("R2 R4 upper halves unused", master_o, 32'h8000_0000);
        @(negedge clk); e2 = '0; e3 = '0;
        tick();
    endtask

    task automatic t_freeze();
        @(negedge clk); e0 = 32'h1;
        tick();
        check("R5 bit0 set", master_o, 32'h8000_0001);
        write_master(32'h0000_0000);
        check("R1 gate cleared", master_o, 32'h0000_0001);
        @(negedge clk); e0 = '0; so = 32'h4;
        tick(); tick(); tick();
        check("R6 held while gated off", master_o, 32'h0000_0001);
        write_master(32'h8000_0000);
        check("R6 gate back, not yet sampled", master_o, 32'h8000_0001);
        tick();
        check("R5 resample after gate", master_o, 32'h8080_0000);
        @(negedge clk); so = '0;
        tick();
    endtask

    task automatic t_msg();
        int cnt;
        @(negedge clk); ctrl = 16'h0001;
        count_pulses(3, cnt);
        check("R7 no pulse without pending", cnt, 0);
        @(negedge clk); e1 = 32'h0001_0000;
        tick();
        check("R9 not yet at summary edge", {31'b0, msg_pulse}, 32'h0);
        tick();
        check("R9 pulse one cycle after condition", {31'b0, msg_pulse}, 32'h1);
        count_pulses(6, cnt);
        check("R9 no retrigger while held", cnt, 0);
        @(negedge clk); e1 = '0;
        count_pulses(3, cnt);
        check("R9 no pulse on fall", cnt, 0);
        @(negedge clk); mi = 32'h2;
        count_pulses(4, cnt);
        check("R9 retrigger on new rise", cnt, 1);
        @(negedge clk); mi = '0;
        tick(); tick();
    endtask

    task automatic t_cap();
        int cnt;
        @(negedge clk); ctrl = 16'h0000; pb = 32'h1;
        count_pulses(4, cnt);
        check("R8 ctrl=0000 blocks", cnt, 0);
        @(negedge clk); ctrl = 16'h0003;
        count_pulses(4, cnt);
        check("R8 ctrl=0003 blocks", cnt, 0);
        @(negedge clk); ctrl = 16'h8001;
        count_pulses(4, cnt);
        check("R8 ctrl=8001 blocks", cnt, 0);
        @(negedge clk); ctrl = 16'h0001;
        count_pulses(4, cnt);
        check("R8 ctrl=0001 fires", cnt, 1);
    endtask

    task automatic t_gate_msg();
        int cnt;
        write_master(32'h0);
        count_pulses(4, cnt);
        check("R7 gate off blocks", cnt, 0);
        write_master(32'h8000_0000);
        count_pulses(4, cnt);
        check("R7 gate on fires", cnt, 1);
        @(negedge clk); pb = '0;
        tick(); tick();
    endtask

    initial begin
        repeat (3) tick();
        @(negedge clk); rst_n = 1'b1;
        tick();
        t_reset();
        t_write();
        t_map();
        t_level();
        t_freeze();
        t_msg();
        t_cap();
        t_gate_msg();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule